// File: doc/BRIEF.md
# Passive-Parallel Configuration Sequencer

This block is a hardware state machine that takes a programmable target device through the control handshake around loading its configuration image over a passive parallel interface. A single `start` pulse launches the sequence. The sequencer first checks the mode-select pins and waits for the target's config-request and status lines to settle high. It then takes over the configuration lines, selects the target and issues a reset pulse on the active-low config request. It checks that config-done is still low and that its output driver is on. After that it enables the configuration control and data paths, so that an external streamer can push the image.

Once the streamer raises `data_done`, the sequencer polls for config-done. It then asks for a short burst of extra data clocks and waits for user mode. Finally it turns off the data paths, gives up the overrides, deselects the target and checks the status lines one last time. Every handshake wait is bounded by a timeout measured in clock cycles. The block reports a busy flag, a success flag and a two-bit error code. It does not stream data or generate the data clock.

Top module: `ppcfg_seq`

## Requirements
- R1: After reset, and while idle, `ncfg_o`=1, `nce_o`=1, `ovr_n_o`=1, `en_ctrl_o`=`en_data_o`=0, `xclk_req_o`=0, `busy_o`=0, `ok_o`=0 and `err_o`=0.
- R2: On `start`, if any bit of `msel_i` above bit 0 is set, the sequencer goes straight to error with `err_o`=2 (permission) and `busy_o` never rises. A value of 0 or 1 lets the sequence run.
- R3: Before it drives anything, the sequencer waits for both `ncfg_pin_i` and `nstatus_i` to read 1. If that does not happen in time, the result is `err_o`=1 (timeout).
- R4: Overrides are enabled (`ovr_n_o`=0) for one cycle while `nce_o` is still 1. Only then is `nce_o` driven to 0. `nce_o` is never 0 while `ovr_n_o` is 1.
- R5: The reset pulse holds `ncfg_o` at 0 until `nstatus_i` reads 0. It then releases `ncfg_o` to 1 and waits for `nstatus_i` to read 1. Either wait can time out with `err_o`=1.
- R6: After the pulse, `conf_done_i` must read 0 and `conf_done_oe_i` must read 1. Otherwise the result is `err_o`=2.
- R7: `en_ctrl_o` and `en_data_o` are 1 from the end of the reset pulse until user mode is seen, and never before the pulse. The wait for `data_done` has no timeout.
- R8: After `data_done`, the sequencer waits for `conf_done_i`=1. If `nstatus_i` reads 0 first, the result is `err_o`=3 (status lost). If neither happens in time, the result is `err_o`=1.
- R9: Once config-done is seen, `xclk_req_o` pulses for exactly one cycle with `xclk_num_o`=15. The sequencer then waits for `user_mode_i`=1, and `err_o`=1 on timeout.
- R10: At teardown, `en_*`=0, `ovr_n_o`=1 and `nce_o`=1. If `user_mode_i`, `conf_done_i` and `nstatus_i` all read 1, the result is `ok_o`=1 and `err_o`=0. Otherwise the result is `err_o`=2.
- R11: Each bounded wait times out after exactly `TMO_CYC` cycles spent in that wait. Error codes are: 0 none, 1 timeout, 2 permission, 3 status lost.
- R12: `busy_o` drops in the success or error state. A new `start` from either state relaunches the sequence and clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken when not busy |
| data_done | input | 1 | End of image stream |
| msel_i | input | MSEL_W | Mode-select pins |
| ncfg_pin_i | input | 1 | Sensed config-request pin (active low) |
| nstatus_i | input | 1 | Target status (active low) |
| conf_done_i | input | 1 | Target config-done |
| conf_done_oe_i | input | 1 | Config-done output-enable indication |
| user_mode_i | input | 1 | Target user-mode indication |
| ncfg_o | output | 1 | Config request drive (active low) |
| nce_o | output | 1 | Chip enable (active low) |
| ovr_n_o | output | 1 | Config line overrides enable (active low) |
| en_ctrl_o | output | 1 | Configuration control path enable |
| en_data_o | output | 1 | Configuration data path enable |
| xclk_req_o | output | 1 | One-cycle request for extra data clocks |
| xclk_num_o | output | XW | Number of extra clocks requested |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Sequence finished successfully |
| err_o | output | 2 | Error code |

## Verification
The bench drives a behavioural target that can inject one fault per run. The faults are a bad mode select, a stuck config-request pin, a status line that never pulses, config-done already high, the output-enable reading off, status lost during the done poll, config-done or user mode never arriving, and status dropping before the final check. A design that mapped any fault to the wrong code, for example reporting a timeout where status was lost, is caught by comparing against the expected code. For the stuck-pin case the bench counts the busy cycles. A timeout counter off by one would end the wait a cycle early or late. Monitors check the edges of the drive order: selecting the target before the overrides are on, enabling the data path before the pulse, or a request pulse longer than one cycle or with the wrong count would all be flagged. Back-to-back runs with no reset in between show that an old error code does not stick.

// File: rtl/ppcfg_seq.sv
module ppcfg_seq #(
  parameter int MSEL_W  = 3,
  parameter int TMO_CYC = 1000,
  parameter int XCLK_N  = 15,
  localparam int CW = $clog2(TMO_CYC + 1),
  localparam int XW = $clog2(XCLK_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          data_done,
  input  logic [MSEL_W-1:0] msel_i,
  input  logic          ncfg_pin_i,
  input  logic          nstatus_i,
  input  logic          conf_done_i,
  input  logic          conf_done_oe_i,
  input  logic          user_mode_i,
  output logic          ncfg_o,
  output logic          nce_o,
  output logic          ovr_n_o,
  output logic          en_ctrl_o,
  output logic          en_data_o,
  output logic          xclk_req_o,
  output logic [XW-1:0] xclk_num_o,
  output logic          busy_o,
  output logic          ok_o,
  output logic [1:0]    err_o
);

  typedef enum logic [3:0] {
    S_IDLE, S_WPIN, S_ARM, S_WPIN2, S_PLO, S_PHI, S_CHK,
    S_STRM, S_WCD, S_XCLK, S_WUM, S_FIN, S_OK, S_ERR
  } st_t;

  localparam logic [1:0] E_NONE = 2'd0;
  localparam logic [1:0] E_TMO  = 2'd1;
  localparam logic [1:0] E_PERM = 2'd2;
  localparam logic [1:0] E_LOST = 2'd3;

  st_t state_q, state_d;
  logic [1:0] err_q, err_d;
  logic [CW-1:0] cnt_q;
  logic tmo, msel_bad;

  assign tmo      = (cnt_q == CW'(TMO_CYC - 1));
  assign msel_bad = |(msel_i >> 1);

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    case (state_q)
      S_IDLE, S_OK, S_ERR:
        if (start) begin
          err_d = E_NONE;
          if (msel_bad) begin
            state_d = S_ERR;
            err_d   = E_PERM;
          end else begin
            state_d = S_WPIN;
          end
        end
      S_WPIN, S_WPIN2:
        if (ncfg_pin_i && nstatus_i) state_d = (state_q == S_WPIN) ? S_ARM : S_PLO;
        else if (tmo) begin state_d = S_ERR; err_d = E_TMO; end
      S_ARM: state_d = S_WPIN2;
      S_PLO:
        if (!nstatus_i) state_d = S_PHI;
        else if (tmo) begin state_d = S_ERR; err_d = E_TMO; end
      S_PHI:
        if (nstatus_i) state_d = S_CHK;
        else if (tmo) begin state_d = S_ERR; err_d = E_TMO; end
      S_CHK:
        if (!conf_done_i && conf_done_oe_i) state_d = S_STRM;
        else begin state_d = S_ERR; err_d = E_PERM; end
      S_STRM:
        if (data_done) state_d = S_WCD;
      S_WCD:
        if (conf_done_i) state_d = S_XCLK;
        else if (!nstatus_i) begin state_d = S_ERR; err_d = E_LOST; end
        else if (tmo) begin state_d = S_ERR; err_d = E_TMO; end
      S_XCLK: state_d = S_WUM;
      S_WUM:
        if (user_mode_i) state_d = S_FIN;
        else if (tmo) begin state_d = S_ERR; err_d = E_TMO; end
      S_FIN:
        if (user_mode_i && conf_done_i && nstatus_i) state_d = S_OK;
        else begin state_d = S_ERR; err_d = E_PERM; end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      err_q   <= E_NONE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
    end
  end

  logic selected, overridden, paths_on;
  assign selected   = state_q inside {S_WPIN2, S_PLO, S_PHI, S_CHK, S_STRM, S_WCD, S_XCLK, S_WUM};
  assign overridden = selected || (state_q == S_ARM);
  assign paths_on   = state_q inside {S_STRM, S_WCD, S_XCLK, S_WUM};

  assign ncfg_o     = (state_q != S_PLO);
  assign nce_o      = !selected;
  assign ovr_n_o    = !overridden;
  assign en_ctrl_o  = paths_on;
  assign en_data_o  = paths_on;
  assign xclk_req_o = (state_q == S_XCLK);
  assign xclk_num_o = xclk_req_o ? XW'(XCLK_N) : '0;
  assign busy_o     = !(state_q inside {S_IDLE, S_OK, S_ERR});
  assign ok_o       = (state_q == S_OK);
  assign err_o      = err_q;

  // R4
  sel_needs_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nce_o |-> !ovr_n_o);

  // R7
  data_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_data_o |-> (!nce_o && ncfg_o));

  // R9
  xclk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xclk_req_o |=> !xclk_req_o);

  // R2
  msel_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start && msel_bad) |=> (err_o == E_PERM && !busy_o));

  // R8
  status_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WCD && !conf_done_i && !nstatus_i) |=> (err_o == E_LOST && !busy_o));

  // R12
  ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (err_o == E_NONE && !busy_o));

endmodule

// File: tb/ppcfg_seq_tb_top.sv
module ppcfg_seq_tb_top;
  localparam int TMO = 16;

  logic clk = 0, rst_n = 0;
  logic start = 0, data_done = 0;
  logic [2:0] msel = 0;
  logic ncfg_pin = 1, nstatus = 1, conf_done = 0, cd_oe = 1, user_mode = 0;
  logic ncfg_o, nce_o, ovr_n_o, en_ctrl_o, en_data_o, xclk_req_o, busy_o, ok_o;
  logic [3:0] xclk_num_o;
  logic [1:0] err_o;

  always #4 clk = ~clk;

  ppcfg_seq #(.MSEL_W(3), .TMO_CYC(TMO), .XCLK_N(15)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .data_done(data_done), .msel_i(msel),
    .ncfg_pin_i(ncfg_pin), .nstatus_i(nstatus), .conf_done_i(conf_done),
    .conf_done_oe_i(cd_oe), .user_mode_i(user_mode),
    .ncfg_o(ncfg_o), .nce_o(nce_o), .ovr_n_o(ovr_n_o), .en_ctrl_o(en_ctrl_o),
    .en_data_o(en_data_o), .xclk_req_o(xclk_req_o), .xclk_num_o(xclk_num_o),
    .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o));

  int n_chk = 0, n_bad = 0;
  int fault = 0, slen = 0, scnt = 0, ccnt = 0, ucnt = 0, xcount = 0;
  bit run_act = 0, dd_sent = 0, kill = 0, xseen = 0;
  bit seen_arm = 0, seen_pulse = 0, bad_order = 0, bad_num = 0, en_seen = 0;
  logic [1:0] shr = 2'b11;
  int cyc = 0;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_err(input int f);
    case (f)
      0: return 0;
      2, 3, 7, 8: return 1;
      6: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string req_of(input int f);
    case (f)
      0: return "R10";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      4, 5: return "R6";
      6, 7: return "R8";
      8: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // behavioural target with fault injection
  always @(negedge clk) if (run_act) begin
    shr = {shr[0], ncfg_o};
    data_done = 0;
    if (en_data_o) en_seen = 1;
    if (!dd_sent && en_data_o) begin
      if (scnt == slen) begin
        data_done = 1; dd_sent = 1;
        if (fault == 6) kill = 1;
      end else scnt++;
    end
    if (dd_sent) ccnt++;
    conf_done = (fault == 4) ? 1'b1 : (dd_sent && ccnt >= 3 && fault != 7);
    if (xclk_req_o) begin
      xseen = 1; xcount++;
      if (xclk_num_o != 4'd15) bad_num = 1;
      if (fault == 9) kill = 1;
    end
    if (xseen) ucnt++;
    user_mode = xseen && ucnt >= 4 && fault != 8;
    nstatus   = kill ? 1'b0 : ((fault == 3) ? 1'b1 : shr[1]);
    ncfg_pin  = (fault == 2) ? 1'b0 : ncfg_o;
    cd_oe     = (fault != 5);
    if (!ovr_n_o && nce_o) seen_arm = 1;
    if (!ncfg_o) seen_pulse = 1;
    if (en_data_o && !seen_pulse) bad_order = 1;
    if (!nce_o && ovr_n_o) bad_order = 1;
  end

  task automatic run(input int f, input logic [2:0] ms, input int len);
    int bcnt;
    fault = f; slen = len; scnt = 0; ccnt = 0; ucnt = 0; xcount = 0;
    dd_sent = 0; kill = 0; xseen = 0; seen_arm = 0; seen_pulse = 0;
    bad_order = 0; bad_num = 0; en_seen = 0; shr = 2'b11;
    nstatus = 1; ncfg_pin = (f == 2) ? 1'b0 : 1'b1; conf_done = (f == 4);
    cd_oe = (f != 5); user_mode = 0; msel = ms; run_act = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    bcnt = 0;
    while (busy_o && bcnt < 400) begin
      bcnt++;
      @(negedge clk);
    end
    check(err_o == exp_err(f), req_of(f), err_o, exp_err(f));
    // R11 R12 ok flag and busy low at the end
    check(ok_o == (exp_err(f) == 0) && !busy_o, "R12", ok_o, exp_err(f) == 0);
    if (f == 2) check(bcnt == TMO, "R11", bcnt, TMO);
    if (f == 1) check(bcnt == 0, "R2", bcnt, 0);
    if (f == 0) begin
      check(seen_arm && !bad_order, "R4", seen_arm, 1);
      check(seen_pulse && en_seen, "R7", en_seen, 1);
      check(xcount == 1 && !bad_num, "R9", xcount, 1);
      check(nce_o && ovr_n_o && !en_ctrl_o && !en_data_o && ncfg_o, "R10",
            {nce_o, ovr_n_o, en_ctrl_o, en_data_o}, 4'b1100);
    end
    run_act = 0;
    @(negedge clk);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h0c0ffee5);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ncfg_o && nce_o && ovr_n_o && !en_ctrl_o && !en_data_o && !xclk_req_o &&
          !busy_o && !ok_o && err_o == 0, "R1", {busy_o, ok_o, err_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy_o && nce_o && ovr_n_o, "R1", busy_o, 0);
    // directed: each fault kind, then msel bit0 accepted
    for (int f = 0; f < 10; f++) run(f, (f == 1) ? 3'b100 : 3'b000, 5);
    run(0, 3'b001, 0);
    run(1, 3'b010, 3);
    run(0, 3'b000, 30);
    // random mix
    for (int i = 0; i < 60; i++) begin
      int f;
      logic [2:0] ms;
      f = ($urandom % 3 == 0) ? 0 : int'($urandom % 10);
      ms = (f == 1) ? (3'($urandom % 6) + 3'd2) : 3'($urandom % 2);
      run(f, ms, int'($urandom % 31));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule